// File: doc/BRIEF.md
# Orbit Period Monitor

The block watches the orbit marker that arrives in the bunch-clock domain and measures, for every orbit, how many bunch-clock cycles have passed since the previous marker. A healthy machine gives a steady value, nominally 3564. When software issues a capture command, the block records a window of consecutive interval measurements into a small buffer and then freezes it. Software reads the buffer afterwards. Values that scatter, that drift away from the nominal, or that sit at the saturation limit show a bad comparator threshold, a phase error or lost synchronisation.

The block also keeps a free-running orbit count that wraps. At the default width it wraps after roughly 106 hours. One clear input resets this count; it serves for a manual reset and for a reset at the start of a run. A presence flag shows whether orbit markers are currently arriving.

Top module: `orbit_mon`

## Requirements
- R1: Each measured interval equals the number of clock cycles between two consecutive rising edges of `orbit_i`.
- R2: An interval longer than 2^CNT_W-1 cycles is stored as 2^CNT_W-1 (all ones).
- R3: After a capture command, the first rising edge of `orbit_i` only starts a measurement, so a partial interval is never stored. A capture command takes priority over an edge in the same cycle, so such an edge does not start the measurement.
- R4: The DEPTH stored intervals go to buffer addresses 0 to DEPTH-1 in arrival order. `rd_data_o` shows the entry at `rd_addr_i` one clock after the address is applied.
- R5: `capture_done_o` rises once DEPTH entries are stored. Further orbits then leave the buffer unchanged until the next command, and that command clears `capture_done_o`.
- R6: `capture_busy_o` is high from the cycle after a command until `capture_done_o` rises. Both flags are low after reset.
- R7: `orbit_cnt_o` increments by one on each rising edge of `orbit_i` and wraps modulo 2^ORB_W. It is 0 after reset.
- R8: `cnt_clr_i` sets `orbit_cnt_o` to 0 on the next clock, even if an orbit edge arrives in the same cycle.
- R9: `orbit_avail_o` is 0 after reset and is 1 in the cycle after an orbit edge. It goes to 0 once TIMEOUT cycles have passed without an edge. An edge that arrives exactly TIMEOUT cycles after the previous one keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| orbit_i | input | 1 | Orbit marker; the rising edge counts |
| capture_i | input | 1 | One-cycle capture command |
| cnt_clr_i | input | 1 | Orbit count clear (manual or at run start) |
| rd_addr_i | input | $clog2(DEPTH) | Buffer read address |
| rd_data_o | output | CNT_W | Buffer read data, one cycle after the address |
| capture_busy_o | output | 1 | Capture armed or filling |
| capture_done_o | output | 1 | Buffer full and frozen |
| orbit_cnt_o | output | ORB_W | Orbit count |
| orbit_avail_o | output | 1 | Orbit markers present |

## Verification
The assertions check on every cycle that an edge restarts the interval count at one and that a saturated count stays saturated. They also check that a command always arms the capture, that a finished capture holds its state and write pointer, that the orbit count steps by exactly one per edge or goes to zero on a clear, and that an edge always raises the presence flag. Only the bench's scenarios can show that the stored values match real gaps, that the arming edge is skipped, that the frozen contents survive later orbits, and where the count wraps. The same holds for the exact cycle at which the presence timeout falls.

// File: rtl/orbit_mon_pkg.sv
package orbit_mon_pkg;
  typedef enum logic [1:0] {CAP_IDLE, CAP_ARM, CAP_FILL, CAP_DONE} cap_state_e;
endpackage

// File: rtl/orbit_interval.sv
module orbit_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             orbit_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] ival_o
);
  localparam logic [CNT_W-1:0] MaxVal = '1;

  logic             orb_q;
  logic [CNT_W-1:0] ival_q;

  assign edge_o = orbit_i & ~orb_q;
  assign ival_o = ival_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      orb_q  <= 1'b0;
      ival_q <= '0;
    end else begin
      orb_q <= orbit_i;
      if (edge_o)                ival_q <= CNT_W'(1);
      else if (ival_q != MaxVal) ival_q <= ival_q + 1'b1;
    end
  end

  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> ival_q == CNT_W'(1));
  a_r2_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ival_q == MaxVal && !edge_o) |=> ival_q == MaxVal);
endmodule

// File: rtl/orbit_capture.sv
module orbit_capture
  import orbit_mon_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] ival_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             busy_o,
  output logic             done_o
);
  cap_state_e       state_q;
  logic [AW-1:0]    wptr_q;
  logic             we;
  logic [CNT_W-1:0] mem_q [DEPTH];

  assign we     = (state_q == CAP_FILL) && edge_i && !capture_i;
  assign busy_o = (state_q == CAP_ARM) || (state_q == CAP_FILL);
  assign done_o = (state_q == CAP_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_IDLE;
      wptr_q  <= '0;
    end else if (capture_i) begin
      state_q <= CAP_ARM;
      wptr_q  <= '0;
    end else begin
      unique case (state_q)
        CAP_ARM:  if (edge_i) state_q <= CAP_FILL;
        CAP_FILL: if (edge_i) begin
          wptr_q <= wptr_q + 1'b1;
          if (wptr_q == AW'(DEPTH - 1)) state_q <= CAP_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (we) mem_q[wptr_q] <= ival_i;
    rd_data_o <= mem_q[rd_addr_i];
  end

  a_r3_cmd_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> state_q == CAP_ARM);
  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CAP_FILL && edge_i && !capture_i)
      |=> (wptr_q == $past(wptr_q) + 1'b1) || (state_q == CAP_DONE));
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CAP_DONE && !capture_i) |=> (state_q == CAP_DONE) && $stable(wptr_q));
  a_r6_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/orbit_count.sv
module orbit_count #(
  parameter int ORB_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             clr_i,
  output logic [ORB_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (edge_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !clr_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/orbit_presence.sv
module orbit_presence #(
  parameter int TIMEOUT = 7128,
  localparam int IW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic avail_o
);
  logic [IW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= '0;
      avail_o <= 1'b0;
    end else if (edge_i) begin
      idle_q  <= '0;
      avail_o <= 1'b1;
    end else if (avail_o) begin
      idle_q <= idle_q + 1'b1;
      if (idle_q + 1'b1 == IW'(TIMEOUT)) avail_o <= 1'b0;
    end
  end

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> avail_o);
  a_r9_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avail_o && !edge_i) |=> !avail_o);
endmodule

// File: rtl/orbit_mon.sv
module orbit_mon #(
  parameter int DEPTH   = 128,
  parameter int CNT_W   = 16,
  parameter int ORB_W   = 32,
  parameter int TIMEOUT = 2 * 3564,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             orbit_i,
  input  logic             capture_i,
  input  logic             cnt_clr_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             capture_busy_o,
  output logic             capture_done_o,
  output logic [ORB_W-1:0] orbit_cnt_o,
  output logic             orbit_avail_o
);
  logic             orb_edge;
  logic [CNT_W-1:0] ival;

  orbit_interval #(.CNT_W(CNT_W)) i_interval (
    .clk_i, .rst_ni, .orbit_i, .edge_o(orb_edge), .ival_o(ival)
  );

  orbit_capture #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_capture (
    .clk_i, .rst_ni, .capture_i, .edge_i(orb_edge), .ival_i(ival),
    .rd_addr_i, .rd_data_o, .busy_o(capture_busy_o), .done_o(capture_done_o)
  );

  orbit_count #(.ORB_W(ORB_W)) i_count (
    .clk_i, .rst_ni, .edge_i(orb_edge), .clr_i(cnt_clr_i), .cnt_o(orbit_cnt_o)
  );

  orbit_presence #(.TIMEOUT(TIMEOUT)) i_presence (
    .clk_i, .rst_ni, .edge_i(orb_edge), .avail_o(orbit_avail_o)
  );
endmodule

// File: tb/test_orbit_mon.sv
`timescale 1ns/1ps
module test_orbit_mon;
  localparam int DEPTH = 8, CNT_W = 6, ORB_W = 8, TIMEOUT = 20;
  localparam int AW = $clog2(DEPTH);
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic orbit_i = 1'b0, capture_i = 1'b0, cnt_clr_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;
  logic capture_busy_o, capture_done_o, orbit_avail_o;
  logic [ORB_W-1:0] orbit_cnt_o;

  int n_chk = 0, n_fail = 0;
  int per [DEPTH];

  always #2 clk_i = ~clk_i;

  orbit_mon #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ORB_W(ORB_W), .TIMEOUT(TIMEOUT)) i_orbit_mon (
    .clk_i, .rst_ni, .orbit_i, .capture_i, .cnt_clr_i, .rd_addr_i, .rd_data_o,
    .capture_busy_o, .capture_done_o, .orbit_cnt_o, .orbit_avail_o
  );

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    orbit_i = 1'b1; tick(); orbit_i = 1'b0;
  endtask

  task automatic orbit(int gap);
    pulse();
    repeat (gap - 1) tick();
  endtask

  task automatic read_chk(string req, int addr, int exp);
    rd_addr_i = AW'(addr); tick();
    chk(req, rd_data_o, exp);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    chk("R9 reset avail", orbit_avail_o, 0);
    chk("R6 reset busy", capture_busy_o, 0);
    chk("R5 reset done", capture_done_o, 0);
    chk("R7 reset count", orbit_cnt_o, 0);

    for (int i = 0; i < DEPTH; i++) per[i] = 4 + 3 * i;
    per[DEPTH-1] = SAT + 7;  // R2 saturating gap

    orbit(7); orbit(7); orbit(7);
    chk("R7 count", orbit_cnt_o, 3);
    repeat (2) tick();  // mid-interval command
    capture_i = 1'b1; tick(); capture_i = 1'b0;
    chk("R6 busy after cmd", capture_busy_o, 1);
    for (int i = 0; i < DEPTH; i++) orbit(per[i]);
    chk("R6 busy while filling", capture_busy_o, 1);
    chk("R5 not done early", capture_done_o, 0);
    orbit(9);
    chk("R5 done", capture_done_o, 1);
    chk("R6 busy cleared", capture_busy_o, 0);
    for (int i = 0; i < DEPTH; i++)
      read_chk("R1 R2 R3 R4 entry", i, per[i] > SAT ? SAT : per[i]);

    orbit(5); orbit(5); orbit(5);
    chk("R5 still done", capture_done_o, 1);
    for (int i = 0; i < DEPTH; i++)
      read_chk("R5 frozen entry", i, per[i] > SAT ? SAT : per[i]);
    chk("R7 count", orbit_cnt_o, 3 + DEPTH + 1 + 3);

    // R9 presence timing
    pulse(); repeat (TIMEOUT - 1) tick();
    chk("R9 before timeout", orbit_avail_o, 1);
    pulse();
    chk("R9 edge at limit", orbit_avail_o, 1);
    repeat (TIMEOUT - 1) tick();
    chk("R9 one short", orbit_avail_o, 1);
    tick();
    chk("R9 timeout", orbit_avail_o, 0);
    repeat (5) tick();
    chk("R9 stays low", orbit_avail_o, 0);
    pulse();
    chk("R9 reset on orbit", orbit_avail_o, 1);

    // R8 clear
    cnt_clr_i = 1'b1; tick(); cnt_clr_i = 1'b0;
    chk("R8 clear", orbit_cnt_o, 0);
    tick();
    orbit_i = 1'b1; cnt_clr_i = 1'b1; tick();
    orbit_i = 1'b0; cnt_clr_i = 1'b0;
    chk("R8 clear beats edge", orbit_cnt_o, 0);
    tick();
    repeat ((1 << ORB_W) - 1) orbit(3);
    chk("R7 full", orbit_cnt_o, (1 << ORB_W) - 1);
    orbit(3);
    chk("R7 wrap", orbit_cnt_o, 0);
    orbit(3);
    chk("R7 after wrap", orbit_cnt_o, 1);

    // R3 recapture with edge in the command cycle
    orbit_i = 1'b1; capture_i = 1'b1; tick();
    orbit_i = 1'b0; capture_i = 1'b0;
    chk("R5 done cleared", capture_done_o, 0);
    chk("R6 busy on recapture", capture_busy_o, 1);
    repeat (5) tick();
    for (int i = 0; i <= DEPTH; i++) orbit(11);
    chk("R5 done again", capture_done_o, 1);
    for (int i = 0; i < DEPTH; i++) read_chk("R3 R4 recapture entry", i, 11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule